// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block decides which DRAM rows get refreshed and when. Each row is refreshed at a rate that matches its retention class, not at one fixed period for every row. A sweep walks every row address in ascending order. One row is visited after each programmable number of idle cycles. A full pass over all rows is one base refresh period.

Two compact Bloom-filter bins record which rows are weak. The first bin holds rows that need refresh every base period. The second bin holds rows that can wait two periods. Any row found in neither bin is refreshed every fourth period. Software fills the filters one bit at a time through a write port. At each visit the block probes the bins from weakest to strongest and compares the row's multiplier with the count of completed sweeps. If the row is due, the block raises a request to the memory scheduler. The request carries the row address and holds until the scheduler accepts it.

A Bloom false positive can only move a row into a more frequent bin, so an aliasing error costs extra refreshes and never loses data. While a request waits, the targeted bank is left to the refresh, and the sweep does not move on.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset no request is pending, the sweep starts at row 0 and the period count is 0. The first request, after any filter programming, is for row 0.
- R2: With `ref_ready` held high, a row that is not due takes `visit_gap`+1 cycles. A due row takes `visit_gap`+2 cycles, measured between accept edges.
- R3: Rows are visited in ascending address order. After the last row (all ones) the sweep wraps to row 0 and the period count increments.
- R4: A row that is a member of bin 0 (the weak bin) is refreshed in every period.
- R5: A row that is a member of bin 1 but not of bin 0 is refreshed only in periods whose count is even.
- R6: A row that is a member of neither bin is refreshed only in periods whose count is a multiple of 4. This includes period 0.
- R7: Bin 0 is checked first, so a row that is a member of both bins is refreshed in every period.
- R8: A row is a member of a bin only if both probed bits are 1. The probe indices come from the row address r, zero-extended to 16 bits: index A = r[7:0] ^ r[15:8], and index B = {r[3:0], r[7:4]} ^ r[15:8] ^ 8'hA5. A single set bit does not make the row a member.
- R9: When `flt_wr_en` is high on a clock edge, that edge writes `flt_wr_val` into bit `flt_wr_idx` of the bin that `flt_wr_bin` selects (0 = weak bin, 1 = two-period bin). The write can set or clear the bit, and it applies to every visit after that edge. Reset clears all filter bits.
- R10: Once `ref_valid` rises, it stays high with `ref_row` stable until an edge where `ref_ready` is high. No other row is visited in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_wr_en | input | 1 | Filter bit write strobe |
| flt_wr_bin | input | 1 | Bin select for the write (0 weak, 1 two-period) |
| flt_wr_idx | input | IDX_W | Bit index within the filter |
| flt_wr_val | input | 1 | Value written to the bit |
| visit_gap | input | GAP_W | Idle cycles before each row visit |
| ref_ready | input | 1 | Scheduler accepts the pending request |
| ref_valid | output | 1 | Refresh request pending |
| ref_row | output | ROW_W | Row address of the pending request |

## Verification
The bench keeps its own mirror of the filter bits and builds the expected order of refreshes and the spacing between accepts. Any error in the period multiplier shows up in this comparison. A design that refreshed strong rows every period, or skipped period 0, would produce extra or missing entries and wrong spacing. Rows that are members of both bins, and rows with only one of their two probe bits set, test the bin order and the rule that both bits must be set. A design that checked the strong bin first, or used OR instead of AND on the probe bits, would put those rows in the wrong bin. A cleared bit must also drop the row's membership. A long stall with `ref_ready` low must hold the row address and freeze the sweep; a design that kept sweeping would show a skipped row after release.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [1:0] {
    BIN_EVERY  = 2'd0,
    BIN_SECOND = 2'd1,
    BIN_FOURTH = 2'd2
  } rbin_e;

  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_REQ  = 1'b1
  } sweep_st_e;

  // Probe index A: fold the two bytes of the row address together.
  function automatic logic [7:0] probe_a(input logic [15:0] r);
    return r[7:0] ^ r[15:8];
  endfunction

  // Probe index B: swap the nibbles of the low byte, fold in the high byte, then XOR a constant.
  function automatic logic [7:0] probe_b(input logic [15:0] r);
    return {r[3:0], r[7:4]} ^ r[15:8] ^ 8'hA5;
  endfunction

  // A row is due when the period count is a multiple of its bin's multiplier.
  function automatic logic bin_due(input rbin_e b, input logic [1:0] per_lo);
    logic d;
    case (b)
      BIN_EVERY:  d = 1'b1;
      BIN_SECOND: d = (per_lo[0] == 1'b0);
      default:    d = (per_lo == 2'b00);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rrs_bloom_bin.sv
module rrs_bloom_bin #(
  parameter int ROW_W    = 10,
  parameter int FLT_BITS = 256,
  localparam int IDX_W   = $clog2(FLT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [ROW_W-1:0] probe_row,
  output logic             hit
);
  import rrs_pkg::*;

  logic [FLT_BITS-1:0] bits_q;
  logic [15:0]         row16;
  logic [7:0]          ha;
  logic [7:0]          hb;
  logic [IDX_W-1:0]    ia;
  logic [IDX_W-1:0]    ib;

  assign row16 = 16'(probe_row);
  assign ha    = probe_a(row16);
  assign hb    = probe_b(row16);
  assign ia    = ha[IDX_W-1:0];
  assign ib    = hb[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (wr_en) begin
      bits_q[wr_idx] <= wr_val;
    end
  end

  // Membership needs both probed bits.
  assign hit = bits_q[ia] & bits_q[ib];

endmodule

// File: rtl/rrs_classify.sv
module rrs_classify (
  input  logic           hit_weak,
  input  logic           hit_mid,
  input  logic [1:0]     per_lo,
  output rrs_pkg::rbin_e row_bin,
  output logic           row_due
);
  import rrs_pkg::*;

  // Weakest bin first: aliasing can only raise the refresh rate.
  always_comb begin
    if (hit_weak)     row_bin = BIN_EVERY;
    else if (hit_mid) row_bin = BIN_SECOND;
    else              row_bin = BIN_FOURTH;
  end

  assign row_due = bin_due(row_bin, per_lo);

endmodule

// File: rtl/rrs_sweep.sv
module rrs_sweep #(
  parameter int ROW_W = 10,
  parameter int GAP_W = 16,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] visit_gap,
  input  logic             row_due,
  input  logic             ref_ready,
  output logic [ROW_W-1:0] cur_row,
  output logic [PER_W-1:0] period,
  output logic             visit_evt,
  output logic             sweep_adv,
  output logic             sweep_wrap,
  output logic             ref_fire,
  output logic             ref_valid
);
  import rrs_pkg::*;

  localparam logic [ROW_W-1:0] LAST_ROW = '1;

  sweep_st_e        st_q;
  logic [GAP_W-1:0] gap_q;

  assign visit_evt  = (st_q == SW_IDLE) && (gap_q >= visit_gap);
  assign ref_fire   = (st_q == SW_REQ) && ref_ready;
  assign sweep_adv  = (visit_evt && !row_due) || ref_fire;
  assign sweep_wrap = sweep_adv && (cur_row == LAST_ROW);
  assign ref_valid  = (st_q == SW_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SW_IDLE;
      gap_q   <= '0;
      cur_row <= '0;
      period  <= '0;
    end else begin
      case (st_q)
        SW_IDLE: begin
          if (visit_evt) begin
            gap_q <= '0;
            if (row_due) st_q <= SW_REQ;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: begin
          gap_q <= '0;
          if (ref_ready) st_q <= SW_IDLE;
        end
      endcase
      if (sweep_adv)  cur_row <= cur_row + 1'b1;
      if (sweep_wrap) period  <= period + 1'b1;
    end
  end

endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched #(
  parameter int ROW_W    = 10,
  parameter int FLT_BITS = 256,
  parameter int GAP_W    = 16,
  parameter int PER_W    = 8,
  localparam int IDX_W   = $clog2(FLT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_wr_en,
  input  logic             flt_wr_bin,
  input  logic [IDX_W-1:0] flt_wr_idx,
  input  logic             flt_wr_val,
  input  logic [GAP_W-1:0] visit_gap,
  input  logic             ref_ready,
  output logic             ref_valid,
  output logic [ROW_W-1:0] ref_row
);
  import rrs_pkg::*;

  localparam int NBINS = 2;

  logic [NBINS-1:0] hit_vec;
  logic [ROW_W-1:0] cur_row;
  logic [PER_W-1:0] period;
  logic             visit_evt;
  logic             sweep_adv;
  logic             sweep_wrap;
  logic             ref_fire;
  logic             row_due;
  rbin_e            row_bin;

  for (genvar g = 0; g < NBINS; g++) begin : g_bin
    logic bin_wr;
    assign bin_wr = flt_wr_en && (flt_wr_bin == 1'(g));
    rrs_bloom_bin #(.ROW_W(ROW_W), .FLT_BITS(FLT_BITS)) u_bin (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bin_wr),
      .wr_idx   (flt_wr_idx),
      .wr_val   (flt_wr_val),
      .probe_row(cur_row),
      .hit      (hit_vec[g])
    );
  end

  rrs_classify u_cls (
    .hit_weak(hit_vec[0]),
    .hit_mid (hit_vec[1]),
    .per_lo  (period[1:0]),
    .row_bin (row_bin),
    .row_due (row_due)
  );

  rrs_sweep #(.ROW_W(ROW_W), .GAP_W(GAP_W), .PER_W(PER_W)) u_swp (
    .clk       (clk),
    .rst_n     (rst_n),
    .visit_gap (visit_gap),
    .row_due   (row_due),
    .ref_ready (ref_ready),
    .cur_row   (cur_row),
    .period    (period),
    .visit_evt (visit_evt),
    .sweep_adv (sweep_adv),
    .sweep_wrap(sweep_wrap),
    .ref_fire  (ref_fire),
    .ref_valid (ref_valid)
  );

  assign ref_row = cur_row;

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int ROW_W = 10,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_valid,
  input logic             ref_ready,
  input logic [ROW_W-1:0] ref_row,
  input logic             visit_evt,
  input logic             row_due,
  input logic             hit_weak,
  input logic             hit_mid,
  input logic [PER_W-1:0] period,
  input logic             sweep_wrap,
  input logic             ref_fire
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !ref_ready) |=> (ref_valid && $stable(ref_row)));

  p_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> !visit_evt);

  p_weak_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_evt && hit_weak) |-> row_due);

  p_slow_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_evt && !hit_weak && !hit_mid && (period[1:0] != 2'b00)) |-> !row_due);

  p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_evt && row_due) |=> ref_valid);

  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_evt && !row_due) |=> !ref_valid);

  p_wrap_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_wrap |=> (period == PER_W'($past(period) + 1'b1)));

  p_fire_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> !ref_valid);

endmodule

bind retention_refresh_sched rrs_checker #(.ROW_W(ROW_W), .PER_W(PER_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_valid (ref_valid),
  .ref_ready (ref_ready),
  .ref_row   (ref_row),
  .visit_evt (visit_evt),
  .row_due   (row_due),
  .hit_weak  (hit_vec[0]),
  .hit_mid   (hit_vec[1]),
  .period    (period),
  .sweep_wrap(sweep_wrap),
  .ref_fire  (ref_fire)
);

// File: tb/retention_refresh_sched_bench.sv
module retention_refresh_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TROW_W     = 5;
  localparam int TROWS      = 1 << TROW_W;
  localparam int TGAP_W     = 8;
  localparam int MAXOBS     = 512;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              flt_wr_en;
  logic              flt_wr_bin;
  logic [7:0]        flt_wr_idx;
  logic              flt_wr_val;
  logic [TGAP_W-1:0] visit_gap;
  logic              ref_ready;
  logic              ref_valid;
  logic [TROW_W-1:0] ref_row;

  retention_refresh_sched #(.ROW_W(TROW_W), .FLT_BITS(256), .GAP_W(TGAP_W), .PER_W(8))
    u_retention_refresh_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .flt_wr_en (flt_wr_en),
    .flt_wr_bin(flt_wr_bin),
    .flt_wr_idx(flt_wr_idx),
    .flt_wr_val(flt_wr_val),
    .visit_gap (visit_gap),
    .ref_ready (ref_ready),
    .ref_valid (ref_valid),
    .ref_row   (ref_row)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;
  bit rec_on = 0;
  int n_obs = 0;
  int obs_row [MAXOBS];
  int obs_t   [MAXOBS];
  logic [255:0] mbits [2];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rec_on && ref_valid && ref_ready && n_obs < MAXOBS) begin
      obs_row[n_obs] = int'(ref_row);
      obs_t[n_obs]   = cyc;
      n_obs++;
    end
  end

  function automatic int hb_a(input int r);
    return (r & 255) ^ ((r >> 8) & 255);
  endfunction

  function automatic int hb_b(input int r);
    int sw;
    sw = ((r & 15) << 4) | ((r >> 4) & 15);
    return (sw ^ ((r >> 8) & 255) ^ 165) & 255;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int g);
    rst_n      = 1'b0;
    ref_ready  = 1'b0;
    flt_wr_en  = 1'b0;
    flt_wr_bin = 1'b0;
    flt_wr_idx = '0;
    flt_wr_val = 1'b0;
    visit_gap  = TGAP_W'(g);
    rec_on     = 0;
    n_obs      = 0;
    mbits[0]   = '0;
    mbits[1]   = '0;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(ref_valid == 1'b0, "R1", "valid in reset", int'(ref_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_bit(input int b, input int idx, input bit v);
    @(negedge clk);
    flt_wr_en  = 1'b1;
    flt_wr_bin = b[0];
    flt_wr_idx = 8'(idx);
    flt_wr_val = v;
    mbits[b][idx] = v;
    @(negedge clk);
    flt_wr_en = 1'b0;
  endtask

  task automatic add_row(input int b, input int r);
    wr_bit(b, hb_a(r), 1'b1);
    wr_bit(b, hb_b(r), 1'b1);
  endtask

  // Expected refresh order and accept spacing from the bench's own filter mirror.
  task automatic run_check(input int g, input int k, input string req);
    int erow [MAXOBS];
    int eskip[MAXOBS];
    int ne = 0;
    int skip = 0;
    for (int p = 0; ne < k; p++) begin
      for (int r = 0; r < TROWS && ne < k; r++) begin
        bit w, m, due;
        w = mbits[0][hb_a(r)] && mbits[0][hb_b(r)];
        m = mbits[1][hb_a(r)] && mbits[1][hb_b(r)];
        if (w)      due = 1;
        else if (m) due = ((p % 2) == 0);
        else        due = ((p % 4) == 0);
        if (due) begin
          erow[ne]  = r;
          eskip[ne] = skip;
          ne++;
          skip = 0;
        end else begin
          skip++;
        end
      end
    end
    @(negedge clk);
    rec_on    = 1;
    ref_ready = 1'b1;
    for (int t = 0; t < 40000 && n_obs < k; t++) @(negedge clk);
    ref_ready = 1'b0;
    rec_on    = 0;
    check(n_obs >= k, req, "handshake count", n_obs, k);
    for (int i = 0; i < k && i < n_obs; i++) begin
      check(obs_row[i] == erow[i], req, $sformatf("row of refresh %0d", i), obs_row[i], erow[i]);
      if (i > 0)
        check(obs_t[i] - obs_t[i-1] == eskip[i]*(g+1) + g + 2, req,
              $sformatf("spacing before refresh %0d", i),
              obs_t[i] - obs_t[i-1], eskip[i]*(g+1) + g + 2);
    end
  endtask

  // R1, R3, R6: empty filters refresh the whole of period 0, then nothing until period 4.
  task automatic t_reset_sweep();
    do_reset(2);
    #(CLK_PERIOD/4);
    check(ref_valid == 1'b0, "R1", "valid just after reset", int'(ref_valid), 0);
    run_check(2, TROWS + 2, "R1/R3/R6");
  endtask

  // R4, R5, R7: weak, two-period and both-bin rows.
  task automatic t_bins();
    do_reset(0);
    add_row(0, 3);
    add_row(0, 10);
    add_row(0, 7);
    add_row(1, 5);
    add_row(1, 20);
    add_row(1, 7);
    run_check(0, 80, "R4/R5/R7");
  endtask

  // R8, R9: lone bits give no membership; a cleared bit removes membership.
  task automatic t_partial();
    do_reset(0);
    wr_bit(0, hb_a(9), 1'b1);
    wr_bit(1, hb_b(12), 1'b1);
    add_row(0, 14);
    wr_bit(0, hb_b(14), 1'b0);
    add_row(1, 17);
    run_check(0, 72, "R8/R9");
  endtask

  // R10: request holds under back-pressure and the sweep does not advance.
  task automatic t_stall();
    do_reset(1);
    for (int t = 0; t < 50 && !ref_valid; t++) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      check(ref_valid == 1'b1, "R10", "valid held", int'(ref_valid), 1);
      check(int'(ref_row) == 0, "R10", "row held", int'(ref_row), 0);
    end
    run_check(1, 40, "R10");
  endtask

  // R2: wider visit spacing.
  task automatic t_gap();
    do_reset(3);
    add_row(0, 1);
    add_row(1, 30);
    run_check(3, 45, "R2");
  endtask

  initial begin
    t_reset_sweep();
    t_bins();
    t_partial();
    t_stall();
    t_gap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule